// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the software-visible control plane of a small display controller. It holds, behind a 32-bit word-addressed register port, the output panel dimensions, the graphics layer placement, size, format and base addresses, the background and transparent key colours, the video timing words and the layer fetch increments. The datapath behind it reads the live contents. The block drives the output enables and layer enable/format decode directly from its registers.

It also collects events into an interrupt status word. Each status bit is cleared by writing one to it, and the status word is gated by an enable word onto a single level interrupt line. A frame-done strobe sets status bit 0. A write to the system configuration word with bit 1 set returns every field to its default. Any write that changes what appears on screen produces a one-cycle invalidate pulse, so the pixel pipeline knows to refetch.

Top module: `dcr_reg_unit`

## Requirements
- R1: After reset, the capability word reads 0x161 and both increment words (0x68, 0x6C) read 1. The control word, both panel-size words and the layer-size word read 0, which encodes a 1x1 area. The irq output and the invalidate output are low.
- R2: The register map uses byte offsets, one word each: 0x00 ready, 0x04 sysconfig, 0x08 irq status, 0x0C irq enable, 0x10 control, 0x14 config, 0x18 capability, 0x1C/0x20 background colours, 0x24/0x28 key colours, 0x2C line status, 0x30 line number, 0x34/0x38 horizontal/vertical timing, 0x3C polarity, 0x40 divisor, 0x44 digital size, 0x48 LCD size, 0x4C/0x50 layer bases, 0x54 layer position, 0x58 layer size, 0x5C layer attributes, 0x60 FIFO threshold, 0x64 FIFO size, 0x68 row increment, 0x6C pixel increment, 0x70 window skip, 0x74 palette base.
- R3: A written value is stored ANDed with a per-register mask, and reads return the stored value. The masks are: control 0x07FF9FFF; config 0x3FFF; capability 0x3FF; colours 0xFFFFFF; line number 0x7FF; timing 0x0FF0FF3F; polarity 0x3FFFF; divisor 0x00FF00FF; attributes 0x7FF; threshold 0x01FF01FF; sysconfig 0x301B. Bases, increments, window skip and palette base keep all 32 bits.
- R4: The size and position words hold X (width minus one for sizes) in bits 10:0 and Y (height minus one for sizes) in bits 26:16. They read back in the same encoding, so the mask is 0x07FF07FF.
- R5: The ready word reads 1, line status reads 0x7FF and FIFO size reads 256. Writes to these three words have no effect. Unaligned or unmapped addresses read 0, and writes to them change nothing.
- R6: Writing the irq status word clears every bit written as one. Bits written as zero keep their value.
- R7: A frame_done pulse sets status bit 0 at the next clock edge. If a write that clears bit 0 lands in the same cycle, the bit stays set.
- R8: The irq enable word keeps its low 16 bits. irq is high exactly when some status bit and the matching enable bit are both one, as stored after the most recent edge.
- R9: Control bit 0 drives lcd_enable and control bit 1 drives dig_enable. Attribute bit 0 drives gfx_enable and attribute bits 4:1 drive gfx_format.
- R10: A write to sysconfig with bit 1 set restores every field to its reset value and clears irq status and irq enable. Sysconfig itself takes the masked written value. A frame_done in the same cycle still sets status bit 0.
- R11: invalidate is high for exactly the cycle after a write to any of these words: control, config, the four colours, the two panel sizes, the layer bases, the palette base, the position, the layer size, the attributes or the two increments. Writes to any other word leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| frame_done | input | 1 | Frame completion event, one cycle |
| irq | output | 1 | Level interrupt: any enabled status bit set |
| invalidate | output | 1 | One-cycle pulse after a content-affecting write |
| lcd_enable | output | 1 | LCD output enable (control bit 0) |
| dig_enable | output | 1 | Digital output enable (control bit 1) |
| gfx_enable | output | 1 | Graphics layer enable (attribute bit 0) |
| gfx_format | output | 4 | Graphics layer pixel format code |

## Verification
Two functions can act on status bit 0 in the same cycle: the hardware set from frame_done, and the software clear through the status word (or the full clear done by a soft reset). The bench first sets the bit, then raises frame_done in the same cycle as a write of one to the status word. It expects the bit, and with it irq, to read as one afterwards. A second case pairs frame_done with a soft reset and expects every other field back at its default while bit 0 stays set.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DATA_W       = 32;
    localparam int NUM_REGS     = 30;
    localparam int REG_IDX_W    = 6;
    localparam int SOFT_RST_BIT = 1;
    localparam int LCD_EN_BIT   = 0;
    localparam int DIG_EN_BIT   = 1;
    localparam int GFX_EN_BIT   = 0;
    localparam int FMT_LSB      = 1;
    localparam int FMT_W        = 4;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_READY, RG_SYSCFG, RG_IRQ_STAT, RG_IRQ_EN, RG_CTRL, RG_CONFIG,
        RG_CAPAB, RG_BG0, RG_BG1, RG_KEY0, RG_KEY1, RG_LINE_STAT,
        RG_LINE_NUM, RG_TIM_H, RG_TIM_V, RG_POL, RG_DIV, RG_SIZE_DIG,
        RG_SIZE_LCD, RG_BASE0, RG_BASE1, RG_POS, RG_SIZE, RG_ATTR,
        RG_THRESH, RG_FIFO_SZ, RG_ROW_INC, RG_PIX_INC, RG_WIN_SKIP,
        RG_PAL_BASE
    } reg_idx_e;

    typedef struct packed {
        logic              valid;
        reg_idx_e          idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] reg_wmask(reg_idx_e i);
        case (i)
            RG_SYSCFG:                          return 32'h0000_301B;
            RG_CTRL:                            return 32'h07FF_9FFF;
            RG_CONFIG:                          return 32'h0000_3FFF;
            RG_CAPAB:                           return 32'h0000_03FF;
            RG_BG0, RG_BG1, RG_KEY0, RG_KEY1:   return 32'h00FF_FFFF;
            RG_LINE_NUM:                        return 32'h0000_07FF;
            RG_TIM_H, RG_TIM_V:                 return 32'h0FF0_FF3F;
            RG_POL:                             return 32'h0003_FFFF;
            RG_DIV:                             return 32'h00FF_00FF;
            RG_SIZE_DIG, RG_SIZE_LCD,
            RG_POS, RG_SIZE:                    return 32'h07FF_07FF;
            RG_ATTR:                            return 32'h0000_07FF;
            RG_THRESH:                          return 32'h01FF_01FF;
            RG_BASE0, RG_BASE1, RG_ROW_INC, RG_PIX_INC,
            RG_WIN_SKIP, RG_PAL_BASE:           return 32'hFFFF_FFFF;
            default:                            return 32'h0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(reg_idx_e i);
        case (i)
            RG_CAPAB:               return 32'h0000_0161;
            RG_ROW_INC, RG_PIX_INC: return 32'h0000_0001;
            default:                return 32'h0;
        endcase
    endfunction

    // Words held in the configuration file (others are constants or irq state)
    function automatic logic reg_stored(reg_idx_e i);
        case (i)
            RG_READY, RG_IRQ_STAT, RG_IRQ_EN, RG_LINE_STAT, RG_FIFO_SZ: return 1'b0;
            default:                                                     return 1'b1;
        endcase
    endfunction

    // Words whose update changes displayed content
    function automatic logic reg_dirty(reg_idx_e i);
        case (i)
            RG_CTRL, RG_CONFIG, RG_BG0, RG_BG1, RG_KEY0, RG_KEY1,
            RG_SIZE_DIG, RG_SIZE_LCD, RG_BASE0, RG_BASE1, RG_POS,
            RG_SIZE, RG_ATTR, RG_ROW_INC, RG_PIX_INC, RG_PAL_BASE: return 1'b1;
            default:                                              return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dcr_cfg_file.sv
module dcr_cfg_file
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    output logic [DATA_W-1:0] q [NUM_REGS],
    output logic              soft_rst,
    output logic              invalidate
);

    localparam int CAPAB_I = int'(RG_CAPAB);
    localparam int ROW_I   = int'(RG_ROW_INC);

    assign soft_rst = wr.valid && (wr.idx == RG_SYSCFG) && wr.data[SOFT_RST_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam reg_idx_e ID = reg_idx_e'(g);
        if (reg_stored(ID)) begin : g_st
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= reg_reset(ID);
                else if (soft_rst)
                    r <= (ID == RG_SYSCFG) ? (wr.data & reg_wmask(ID)) : reg_reset(ID);
                else if (wr.valid && (wr.idx == ID))
                    r <= wr.data & reg_wmask(ID);
            end
            assign q[g] = r;
        end else begin : g_const
            assign q[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) invalidate <= 1'b0;
        else     invalidate <= wr.valid && reg_dirty(wr.idx);
    end

    a_r10_soft_defaults: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (q[CAPAB_I] == 32'h161) && (q[ROW_I] == 32'h1));
    a_r11_inval_on_ctrl: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.idx == RG_CTRL) |=> invalidate);
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !wr.valid |=> !invalidate);

endmodule

// File: rtl/dcr_irq_ctrl.sv
module dcr_irq_ctrl #(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              stat_we,
    input  logic              en_we,
    input  logic [STAT_W-1:0] wbits,
    input  logic              frame_done,
    output logic [STAT_W-1:0] stat,
    output logic [STAT_W-1:0] en,
    output logic              irq
);

    logic [STAT_W-1:0] set_vec;
    assign set_vec = {{(STAT_W-1){1'b0}}, frame_done};

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            if (soft_rst)     stat <= set_vec;
            else if (stat_we) stat <= (stat & ~wbits) | set_vec;
            else              stat <= stat | set_vec;
            if (soft_rst)     en <= '0;
            else if (en_we)   en <= wbits;
        end
    end

    assign irq = |(stat & en);

    a_r7_frame_sets: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> stat[0]);
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !frame_done && !soft_rst) |=> ((stat & $past(wbits)) == '0));
    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !soft_rst) |=> ((($past(stat) & ~$past(wbits)) & ~stat) == '0));
    a_r10_enable_cleared: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (en == '0));

endmodule

// File: rtl/dcr_rd_mux.sv
module dcr_rd_mux
    import dcr_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              hit,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] q [NUM_REGS],
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] en,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (idx)
                RG_READY:     rdata = 32'h1;
                RG_IRQ_STAT:  rdata = DATA_W'(stat);
                RG_IRQ_EN:    rdata = DATA_W'(en);
                RG_LINE_STAT: rdata = 32'h7FF;
                RG_FIFO_SZ:   rdata = 32'h100;
                default:      rdata = q[idx];
            endcase
        end
    end

endmodule

// File: rtl/dcr_reg_unit.sv
module dcr_reg_unit
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STAT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic                   frame_done,
    output logic                   irq,
    output logic                   invalidate,
    output logic                   lcd_enable,
    output logic                   dig_enable,
    output logic                   gfx_enable,
    output logic [FMT_W-1:0]       gfx_format
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int CTRL_I = int'(RG_CTRL);
    localparam int ATTR_I = int'(RG_ATTR);

    logic [WORD_W-1:0] word;
    logic              hit;
    reg_idx_e          idx;
    wr_req_t           wr;
    logic [DATA_W-1:0] q [NUM_REGS];
    logic              soft_rst;
    logic [STAT_W-1:0] stat, en;

    assign word = addr[ADDR_W-1:2];
    assign hit  = (addr[1:0] == 2'b00) && (int'(word) < NUM_REGS);
    assign idx  = reg_idx_e'(word[REG_IDX_W-1:0]);
    assign wr   = '{valid: wr_en && hit, idx: idx, data: wdata};

    dcr_cfg_file u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .q          (q),
        .soft_rst   (soft_rst),
        .invalidate (invalidate)
    );

    dcr_irq_ctrl #(.STAT_W(STAT_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .stat_we    (wr.valid && idx == RG_IRQ_STAT),
        .en_we      (wr.valid && idx == RG_IRQ_EN),
        .wbits      (wdata[STAT_W-1:0]),
        .frame_done (frame_done),
        .stat       (stat),
        .en         (en),
        .irq        (irq)
    );

    dcr_rd_mux #(.STAT_W(STAT_W)) u_rd (
        .hit   (hit),
        .idx   (idx),
        .q     (q),
        .stat  (stat),
        .en    (en),
        .rdata (rdata)
    );

    assign lcd_enable = q[CTRL_I][LCD_EN_BIT];
    assign dig_enable = q[CTRL_I][DIG_EN_BIT];
    assign gfx_enable = q[ATTR_I][GFX_EN_BIT];
    assign gfx_format = q[ATTR_I][FMT_LSB +: FMT_W];

    a_r5_miss_no_inval: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> !invalidate);
    a_r9_ctrl_follows: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(CTRL_I * 4) && !wdata[LCD_EN_BIT]) |=> !lcd_enable);

endmodule

// File: tb/test_dcr_reg_unit.sv
module test_dcr_reg_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        frame_done = 1'b0;
    logic [31:0] rdata;
    logic        irq, invalidate, lcd_enable, dig_enable, gfx_enable;
    logic [3:0]  gfx_format;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dcr_reg_unit i_dcr_reg_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .frame_done(frame_done), .irq(irq),
        .invalidate(invalidate), .lcd_enable(lcd_enable),
        .dig_enable(dig_enable), .gfx_enable(gfx_enable),
        .gfx_format(gfx_format)
    );

    // {addr, write data, expected read, expected invalidate}
    localparam logic [72:0] VEC [19] = '{
        {8'h10, 32'hFFFF_FFFF, 32'h07FF_9FFF, 1'b1},  // R3 control
        {8'h14, 32'hFFFF_FFFF, 32'h0000_3FFF, 1'b1},  // R3 config
        {8'h18, 32'hFFFF_FFFF, 32'h0000_03FF, 1'b0},  // R3 capability
        {8'h1C, 32'hFFFF_FFFF, 32'h00FF_FFFF, 1'b1},  // R3 colour
        {8'h28, 32'hAB12_3456, 32'h0012_3456, 1'b1},  // R3 key colour
        {8'h30, 32'hFFFF_FFFF, 32'h0000_07FF, 1'b0},  // R3 line number
        {8'h34, 32'hFFFF_FFFF, 32'h0FF0_FF3F, 1'b0},  // R3 timing
        {8'h40, 32'hFFFF_FFFF, 32'h00FF_00FF, 1'b0},  // R3 divisor
        {8'h48, 32'hFFFF_FFFF, 32'h07FF_07FF, 1'b1},  // R4 panel size
        {8'h54, 32'h0123_0456, 32'h0123_0456, 1'b1},  // R4 position
        {8'h5C, 32'hFFFF_FFFF, 32'h0000_07FF, 1'b1},  // R3 attributes
        {8'h60, 32'hFFFF_FFFF, 32'h01FF_01FF, 1'b0},  // R3 threshold
        {8'h68, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1},  // R3 row increment
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0},  // R8 enable
        {8'h00, 32'h0000_0000, 32'h0000_0001, 1'b0},  // R5 ready
        {8'h2C, 32'h0000_0000, 32'h0000_07FF, 1'b0},  // R5 line status
        {8'h64, 32'h0000_0000, 32'h0000_0100, 1'b0},  // R5 fifo size
        {8'h78, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R5 unmapped
        {8'h12, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}   // R5 unaligned
    };

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h18, v); chk("R1 capability", v, 32'h161);
        rd(8'h68, v); chk("R1 row increment", v, 32'h1);
        rd(8'h6C, v); chk("R1 pixel increment", v, 32'h1);
        rd(8'h10, v); chk("R1 control", v, 32'h0);
        rd(8'h58, v); chk("R1 layer size 1x1", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 invalidate", {31'b0, invalidate}, 32'h0);

        // R2/R3/R4/R5/R11 table walk
        for (int i = 0; i < 19; i++) begin
            wr(VEC[i][72:65], VEC[i][64:33]);
            chk($sformatf("R11 invalidate entry %0d", i), {31'b0, invalidate}, {31'b0, VEC[i][0]});
            rd(VEC[i][72:65], v);
            chk($sformatf("R3 readback entry %0d", i), v, VEC[i][32:1]);
        end
        @(negedge clk);
        chk("R11 pulse one cycle", {31'b0, invalidate}, 32'h0);
        rd(8'h10, v); chk("R5 control untouched by misses", v, 32'h07FF_9FFF);

        // R9 decode
        wr(8'h10, 32'h0000_0002);
        chk("R9 lcd_enable", {31'b0, lcd_enable}, 32'h0);
        chk("R9 dig_enable", {31'b0, dig_enable}, 32'h1);
        wr(8'h5C, 32'h0000_000B);
        chk("R9 gfx_enable", {31'b0, gfx_enable}, 32'h1);
        chk("R9 gfx_format", {28'b0, gfx_format}, 32'h5);

        // R7/R8 frame done with enable 0xFFFF already set
        chk("R8 irq idle", {31'b0, irq}, 32'h0);
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        rd(8'h08, v); chk("R7 status set", v, 32'h1);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'h0000_0000);
        rd(8'h08, v); chk("R6 zero write keeps", v, 32'h1);
        wr(8'h0C, 32'h0000_0000);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h0000_0001);
        chk("R8 irq re-enabled", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'h0000_0001);
        rd(8'h08, v); chk("R6 one write clears", v, 32'h0);
        chk("R8 irq after clear", {31'b0, irq}, 32'h0);

        // R7 set wins over same-cycle clear
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        @(negedge clk);
        frame_done = 1'b1; wr_en = 1'b1; addr = 8'h08; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        frame_done = 1'b0; wr_en = 1'b0;
        rd(8'h08, v); chk("R7 set beats clear", v, 32'h1);
        chk("R7 irq stays", {31'b0, irq}, 32'h1);

        // R10 soft reset with simultaneous frame_done
        @(negedge clk);
        frame_done = 1'b1; wr_en = 1'b1; addr = 8'h04; wdata = 32'h0000_FFFF;
        @(negedge clk);
        frame_done = 1'b0; wr_en = 1'b0;
        chk("R11 no pulse on sysconfig", {31'b0, invalidate}, 32'h0);
        rd(8'h04, v); chk("R10 sysconfig masked", v, 32'h301B);
        rd(8'h10, v); chk("R10 control default", v, 32'h0);
        rd(8'h18, v); chk("R10 capability default", v, 32'h161);
        rd(8'h68, v); chk("R10 row increment default", v, 32'h1);
        rd(8'h48, v); chk("R10 panel size default", v, 32'h0);
        rd(8'h0C, v); chk("R10 enable cleared", v, 32'h0);
        rd(8'h08, v); chk("R10 frame_done still sets", v, 32'h1);
        chk("R10 irq low", {31'b0, irq}, 32'h0);
        chk("R10 lcd/dig off", {30'b0, lcd_enable, dig_enable}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule